// File: doc/BRIEF.md
# Fixed-Priority Five-Port Switch Allocator

This block settles contention for the output channels of a five-port mesh router. The ports are local, west, north, east and south. Each input buffer presents a request vector that names the single output its head packet needs. The allocator answers with a grant to that input and with a one-hot crossbar select for each output, which the switch uses to connect the winning input buffer to the output port. Route computation, buffering and data movement are handled by the neighbouring blocks.

Arbitration is combinational within a cycle. An idle output picks the requester with the highest fixed priority: local first, then west, north, east and south. Once an output has granted an input, it stays with that input while the transfer is in flight, which lasts until the downstream side acknowledges it. If the owning input withdraws its request first, the output is released in the same cycle. The ownership registers are the only state in the block.

Top module: `sw_alloc_fp`

## Requirements
- R1: While reset is asserted, and afterwards, no output holds an owner left over from before. With no requests, every grant and every select is zero.
- R2: Whenever an output that is not held has at least one requester, it grants one of them in the same cycle.
- R3: Each output selects at most one input per cycle. The value on `sel_o[o]` is one-hot or zero, and bit i means input i is selected.
- R4: An output that is not held selects the requesting input with the lowest index. The port indices are local=0, west=1, north=2, east=3, south=4, so local has the highest priority.
- R5: An output that selected an input in the previous cycle, and saw no `out_ack_i` in that cycle, keeps selecting the same input as long as that input still requests it. This holds even when inputs of higher priority are requesting.
- R6: When `out_ack_i[o]` is high in a cycle, the transfer completes at that clock edge. In the next cycle, output o arbitrates afresh by priority.
- R7: If the owning input drops its request, the output is released in the same cycle. It then grants the best remaining requester.
- R8: `gnt_o[i]` is high exactly when some output selects input i. An input is never granted without a request; `req_i[i][o]` is the request of input i for output o.
- R9: The select for an output is all zero in every cycle where that output grants no input.
- R10: An `out_ack_i` on an output that has no selected input has no effect.
- R11: Different outputs arbitrate independently and can grant different inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NPORT x NPORT | Request of input i for output o at `req_i[i][o]`; at most one bit set per input |
| out_ack_i | input | NPORT | Downstream acknowledge for each output, completing the current transfer |
| gnt_o | output | NPORT | Grant for each input |
| sel_o | output | NPORT x NPORT | One-hot crossbar select per output, `sel_o[o][i]` selects input i |

## Verification
Grants and selects depend combinationally on the present requests and the ownership state, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples 1 ns later. Ownership changes caused by a grant, an acknowledge or a released request take effect after the next rising edge. The behavioural reference model therefore updates its owner table only at that edge, and compares the following cycle's outputs against it. Directed sequences cover reset, the priority order, held transfers, acknowledges and withdrawals, and idle acknowledges. These are followed by a stretch of random legal traffic that is compared cycle by cycle.

// File: rtl/sa_pkg.sv
package sa_pkg;
    localparam int NUM_PORTS = 5;

    // Index order is also the priority order (lower index wins).
    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_WEST  = 3'd1,
        PORT_NORTH = 3'd2,
        PORT_EAST  = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;
endpackage

// File: rtl/sa_prio_pick.sv
module sa_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sa_out_ctrl.sv
module sa_out_ctrl #(
    parameter int N = 5
) (
    input  logic [N-1:0] col_req,
    input  logic [N-1:0] own_q,
    input  logic         ack,
    output logic [N-1:0] sel,
    output logic [N-1:0] own_d
);
    logic [N-1:0] keep;
    logic [N-1:0] fresh;

    sa_prio_pick #(.N(N)) u_pick (
        .req  (col_req),
        .pick (fresh)
    );

    always_comb begin
        keep  = own_q & col_req;
        sel   = (keep != '0) ? keep : fresh;
        own_d = ack ? '0 : sel;
    end
endmodule

// File: rtl/sw_alloc_fp.sv
module sw_alloc_fp #(
    parameter int NPORT = sa_pkg::NUM_PORTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0][NPORT-1:0] req_i,
    input  logic [NPORT-1:0]            out_ack_i,
    output logic [NPORT-1:0]            gnt_o,
    output logic [NPORT-1:0][NPORT-1:0] sel_o
);
    typedef struct packed {
        logic [NPORT-1:0][NPORT-1:0] own;
    } state_t;

    state_t state_d, state_q;

    logic [NPORT-1:0] col_w  [NPORT];
    logic [NPORT-1:0] sel_w  [NPORT];
    logic [NPORT-1:0] nown_w [NPORT];

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        for (genvar i = 0; i < NPORT; i++) begin : g_col
            assign col_w[o][i] = req_i[i][o];
        end

        sa_out_ctrl #(.N(NPORT)) u_ctrl (
            .col_req (col_w[o]),
            .own_q   (state_q.own[o]),
            .ack     (out_ack_i[o]),
            .sel     (sel_w[o]),
            .own_d   (nown_w[o])
        );

        assign sel_o[o] = sel_w[o];
    end

    always_comb begin
        state_d = state_q;
        gnt_o   = '0;
        for (int o = 0; o < NPORT; o++) begin
            state_d.own[o] = nown_w[o];
            gnt_o          = gnt_o | sel_w[o];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/sa_alloc_chk.sv
module sa_alloc_chk #(
    parameter int NPORT = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NPORT-1:0][NPORT-1:0] req_i,
    input logic [NPORT-1:0]            out_ack_i,
    input logic [NPORT-1:0]            gnt_o,
    input logic [NPORT-1:0][NPORT-1:0] sel_o
);
    logic                        past_ok;
    logic [NPORT-1:0][NPORT-1:0] prev_sel;
    logic [NPORT-1:0]            prev_ack;
    logic [NPORT-1:0][NPORT-1:0] col;
    logic [NPORT-1:0]            held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            prev_sel <= '0;
            prev_ack <= '0;
        end else begin
            past_ok  <= 1'b1;
            prev_sel <= sel_o;
            prev_ack <= out_ack_i;
        end
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) col[o][i] = req_i[i][o];
            held[o] = past_ok && !prev_ack[o] && ((prev_sel[o] & col[o]) != '0);
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(sel_o[o])); // R3
        AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            held[o] |-> (sel_o[o] == prev_sel[o])); // R5
        AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
            (!held[o] && col[o] != '0) |-> (sel_o[o] != '0)); // R2
        for (genvar i = 0; i < NPORT; i++) begin : g_i
            AST_SEL_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                sel_o[o][i] |-> req_i[i][o]); // R8
            for (genvar j = 0; j < i; j++) begin : g_j
                AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                    (sel_o[o][i] && !held[o]) |-> !req_i[j][o]); // R4
            end
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_g
        AST_NO_GNT_WO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[i] |-> (req_i[i] != '0)); // R8
    end
endmodule

bind sw_alloc_fp sa_alloc_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .out_ack_i (out_ack_i),
    .gnt_o     (gnt_o),
    .sel_o     (sel_o)
);

// File: tb/sw_alloc_fp_tb.sv
module sw_alloc_fp_tb;
    localparam int NP = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NP-1:0][NP-1:0] req = '0;
    logic [NP-1:0]         ack = '0;
    logic [NP-1:0]         gnt;
    logic [NP-1:0][NP-1:0] sel;

    int checks = 0;
    int errors = 0;
    int owner [NP];

    sw_alloc_fp #(.NPORT(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .out_ack_i(ack),
        .gnt_o(gnt), .sel_o(sel)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against model, then advance model at the edge.
    task automatic step(string tag, logic [NP-1:0][NP-1:0] r, logic [NP-1:0] a);
        logic [NP-1:0][NP-1:0] es;
        logic [NP-1:0]         eg;
        int                    win [NP];
        req = r;
        ack = a;
        #1;
        eg = '0;
        es = '0;
        for (int o = 0; o < NP; o++) begin
            win[o] = -1;
            if (owner[o] >= 0 && r[owner[o]][o]) win[o] = owner[o];
            else begin
                for (int i = NP - 1; i >= 0; i--) if (r[i][o]) win[o] = i;
            end
            if (win[o] >= 0) begin
                es[o][win[o]] = 1'b1;
                eg[win[o]]    = 1'b1;
            end
            chk(tag, $sformatf("sel out%0d", o), sel[o], es[o]);
        end
        chk(tag, "gnt", gnt, eg);
        @(posedge clk);
        for (int o = 0; o < NP; o++) owner[o] = a[o] ? -1 : win[o];
        @(negedge clk);
    endtask

    function automatic logic [NP-1:0][NP-1:0] mk(int s0, int s1, int s2, int s3, int s4);
        logic [NP-1:0][NP-1:0] r;
        int d [NP];
        d = '{s0, s1, s2, s3, s4};
        r = '0;
        for (int i = 0; i < NP; i++) if (d[i] >= 0) r[i][d[i]] = 1'b1;
        return r;
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int o = 0; o < NP; o++) owner[o] = -1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "sel in reset", sel[0] | sel[1] | sel[2] | sel[3] | sel[4], '0);
        chk("R1", "gnt in reset", gnt, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", '0, '0);
        step("R9", '0, '1);
        // R1: first request after reset: south alone wins local output
        step("R1", mk(-1, -1, -1, -1, 0), 5'b00001);
        // R2: each input alone, acked each cycle
        for (int i = 0; i < NP; i++) begin
            logic [NP-1:0][NP-1:0] r;
            r = '0;
            r[i][(i + 2) % NP] = 1'b1;
            step("R2", r, '1);
        end
        // R11: five inputs to five distinct outputs at once
        step("R11", mk(3, 4, 0, 1, 2), '1);
        // R4: everyone wants output 2; acked so each cycle is fresh
        step("R4", mk(2, 2, 2, 2, 2), 5'b00100);
        step("R4", mk(-1, 2, 2, 2, 2), 5'b00100);
        step("R4", mk(-1, -1, 2, 2, 2), 5'b00100);
        step("R4", mk(-1, -1, -1, 2, 2), 5'b00100);
        step("R3", mk(-1, -1, -1, -1, 2), 5'b00100);
        // R5: south owns output 3, higher priorities arrive later, no ack
        step("R5", mk(-1, -1, -1, -1, 3), '0);
        step("R5", mk(3, 3, -1, -1, 3), '0);
        step("R5", mk(3, 3, 3, 3, 3), '0);
        // R6: ack completes, local takes over next cycle
        step("R6", mk(3, 3, 3, 3, 3), 5'b01000);
        step("R6", mk(3, 3, 3, 3, 3), '0);
        // R7: owner local withdraws, west wins in the same cycle
        step("R7", mk(-1, 3, 3, 3, 3), '0);
        step("R7", mk(-1, -1, 3, 3, 3), 5'b01000);
        // R10: ack on idle output 1, then north takes it and holds
        step("R10", '0, 5'b00010);
        step("R10", mk(-1, -1, 1, -1, -1), '0);
        step("R10", mk(1, -1, 1, -1, -1), '0);
        step("R8", mk(1, -1, -1, -1, -1), '1);
        // random legal traffic
        for (int n = 0; n < 400; n++) begin
            logic [NP-1:0][NP-1:0] r;
            r = '0;
            for (int i = 0; i < NP; i++) begin
                int d;
                d = int'($urandom_range(0, NP + 1));
                if (d < NP) r[i][d] = 1'b1;
            end
            step("R5", r, NP'($urandom) & NP'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule